// File: doc/BRIEF.md
# T1 Channel Dual-Rail Datapath with Loopbacks and Alarm Fill

This block carries one T1 channel's dual-rail (positive/negative) bit streams between the framer side and the line interface. All logic runs on one fast core clock. The transmit clock from the system side and the receive clock recovered from the line arrive as oversampled levels, and the block finds their edges itself. On the transmit path it takes the system rails on each falling transmit-clock edge and sends them to the line, or sends an alarm fill of all ones or all zeros in their place. On the receive path it presents the recovered line rails to the system side, updated on a receive-clock edge that is chosen by one pin.

Two loopbacks are provided. Local loopback turns the channel's transmit line bits back into the receive outputs and clocks them from the transmit clock, while the line still gets the transmit stream. Remote loopback retransmits the recovered line bits toward the line. It overrides both the alarm fill and the system data.

Top module: `t1_chan_dp`

## Requirements
- R1: With remote loopback off, `line_tpos`/`line_tneg` take the system rails at each falling edge of `sys_tclk`, and `line_tclk` follows `sys_tclk`.
- R2: A rail pair with both bits high is treated as a zero (both low), on transmit and on receive. No rail output pair is ever both high.
- R3: With `ais_en`=1 and `ais_ones`=0, each transmit bit sent is a zero (both transmit rails low), whatever the system data.
- R4: With `ais_en`=1 and `ais_ones`=1, each transmit bit is a mark. Marks alternate between the rails, and the first mark after reset goes on `line_tpos`.
- R5: With local loopback off, `sys_rpos`/`sys_rneg` take the line rails on the rising edge of `line_rclk` when `rx_on_fall`=0, and on its falling edge when `rx_on_fall`=1. The other edge is ignored.
- R6: With `lloop`=1, `sys_rclk` follows `sys_tclk`. The receive outputs take the current transmit line bits on the selected edge of `sys_tclk`, and line receive data is ignored. The line still carries the transmit stream.
- R7: With `rloop`=1, the transmit rails take the cleaned line rails at each rising edge of `line_rclk`, and `line_tclk` follows `line_rclk`. System data and the alarm fill are ignored.
- R8: Reset drives all four rail outputs low and restarts the alarm mark polarity on the positive rail.
- R9: Between strobing edges, the rail outputs hold their values whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples all line and system clocks |
| rst | input | 1 | Synchronous active-high reset |
| sys_tclk | input | 1 | System transmit clock level |
| sys_tpos | input | 1 | System transmit positive rail |
| sys_tneg | input | 1 | System transmit negative rail |
| line_tclk | output | 1 | Transmit clock toward the line |
| line_tpos | output | 1 | Transmit positive rail toward the line |
| line_tneg | output | 1 | Transmit negative rail toward the line |
| line_rclk | input | 1 | Recovered receive clock level |
| line_rpos | input | 1 | Recovered positive rail |
| line_rneg | input | 1 | Recovered negative rail |
| sys_rclk | output | 1 | Receive clock toward the system |
| sys_rpos | output | 1 | Receive positive rail toward the system |
| sys_rneg | output | 1 | Receive negative rail toward the system |
| rx_on_fall | input | 1 | 0: receive outputs update on rising edge, 1: on falling edge |
| lloop | input | 1 | Local loopback enable |
| rloop | input | 1 | Remote loopback enable |
| ais_en | input | 1 | Alarm fill enable |
| ais_ones | input | 1 | Alarm fill pattern: 1 all ones, 0 all zeros |

## Verification
The bench drives the system and line clocks as slow levels. It checks transmit capture only on the falling transmit edge, and it moves the data between receive-clock edges so that a design strobing on the wrong receive edge shows the wrong bit. It checks the alternating mark order of the all-ones fill from reset: a polarity flop that is not reset, or that is not toggled, puts two marks in a row on the same rail. It sets remote loopback together with an active alarm fill to show that loopback wins. In local loopback it injects line data and expects the receive outputs not to change, so a wrong source select shows up at the ports. Both-high inputs on either side must come out as zero.

// File: rtl/t1_chan_pkg.sv
package t1_chan_pkg;

    typedef struct packed {
        logic pos;
        logic neg;
    } rail_t;

    localparam rail_t RAIL_ZERO = '{pos: 1'b0, neg: 1'b0};

    // A pair with both rails high is not a legal symbol: read it as a zero.
    function automatic rail_t rail_clean(input rail_t r);
        rail_t o;
        o = (r.pos && r.neg) ? RAIL_ZERO : r;
        return o;
    endfunction

    // Alarm fill symbol; pol=0 puts the mark on the positive rail.
    function automatic rail_t fill_symbol(input logic ones, input logic pol);
        rail_t o;
        o = RAIL_ZERO;
        if (ones) begin
            o.pos = ~pol;
            o.neg = pol;
        end
        return o;
    endfunction

endpackage

// File: rtl/t1_edge_det.sv
module t1_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
    assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/t1_tx_path.sv
module t1_tx_path
    import t1_chan_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tx_fall,
    input  logic  rx_rise,
    input  rail_t sys_bits,
    input  rail_t line_bits,
    input  logic  ais_en,
    input  logic  ais_ones,
    input  logic  rloop,
    output rail_t tx_q
);
    logic mark_pol;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q     <= RAIL_ZERO;
            mark_pol <= 1'b0;
        end else if (rloop) begin
            if (rx_rise) tx_q <= rail_clean(line_bits);
        end else if (tx_fall) begin
            if (ais_en) begin
                tx_q <= fill_symbol(ais_ones, mark_pol);
                if (ais_ones) mark_pol <= ~mark_pol;
            end else begin
                tx_q <= rail_clean(sys_bits);
            end
        end
    end
endmodule

// File: rtl/t1_rx_path.sv
module t1_rx_path
    import t1_chan_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  strobe,
    input  rail_t src,
    output rail_t rx_q
);
    always_ff @(posedge clk) begin
        if (rst)         rx_q <= RAIL_ZERO;
        else if (strobe) rx_q <= rail_clean(src);
    end
endmodule

// File: rtl/t1_chan_dp.sv
module t1_chan_dp
    import t1_chan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sys_tclk,
    input  logic sys_tpos,
    input  logic sys_tneg,
    output logic line_tclk,
    output logic line_tpos,
    output logic line_tneg,
    input  logic line_rclk,
    input  logic line_rpos,
    input  logic line_rneg,
    output logic sys_rclk,
    output logic sys_rpos,
    output logic sys_rneg,
    input  logic rx_on_fall,
    input  logic lloop,
    input  logic rloop,
    input  logic ais_en,
    input  logic ais_ones
);
    logic  t_rise, t_fall, r_rise, r_fall;
    rail_t sys_bits, line_bits, tx_q, rx_q, rx_src;
    logic  rx_strobe;

    t1_edge_det u_tedge (.clk(clk), .rst(rst), .lvl(sys_tclk),  .rise(t_rise), .fall(t_fall));
    t1_edge_det u_redge (.clk(clk), .rst(rst), .lvl(line_rclk), .rise(r_rise), .fall(r_fall));

    assign sys_bits  = '{pos: sys_tpos,  neg: sys_tneg};
    assign line_bits = '{pos: line_rpos, neg: line_rneg};

    t1_tx_path u_tx (
        .clk(clk), .rst(rst), .tx_fall(t_fall), .rx_rise(r_rise),
        .sys_bits(sys_bits), .line_bits(line_bits),
        .ais_en(ais_en), .ais_ones(ais_ones), .rloop(rloop), .tx_q(tx_q)
    );

    always_comb begin
        if (lloop) begin
            rx_src    = tx_q;
            rx_strobe = rx_on_fall ? t_fall : t_rise;
        end else begin
            rx_src    = line_bits;
            rx_strobe = rx_on_fall ? r_fall : r_rise;
        end
    end

    t1_rx_path u_rx (
        .clk(clk), .rst(rst), .strobe(rx_strobe), .src(rx_src), .rx_q(rx_q)
    );

    assign line_tclk = rloop ? line_rclk : sys_tclk;
    assign line_tpos = tx_q.pos;
    assign line_tneg = tx_q.neg;
    assign sys_rclk  = lloop ? sys_tclk : line_rclk;
    assign sys_rpos  = rx_q.pos;
    assign sys_rneg  = rx_q.neg;
endmodule

// File: rtl/t1_chan_dp_chk.sv
module t1_chan_dp_chk (
    input logic clk,
    input logic rst,
    input logic sys_tclk,
    input logic line_rclk,
    input logic line_rpos,
    input logic line_rneg,
    input logic line_tpos,
    input logic line_tneg,
    input logic sys_rpos,
    input logic sys_rneg,
    input logic rx_on_fall,
    input logic lloop,
    input logic rloop,
    input logic ais_en,
    input logic ais_ones
);
    logic tc_q, rc_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            tc_q <= 1'b0;
            rc_q <= 1'b0;
        end else begin
            tc_q <= sys_tclk;
            rc_q <= line_rclk;
        end
    end

    wire tf = tc_q & ~sys_tclk;
    wire tr = ~tc_q & sys_tclk;
    wire rr = ~rc_q & line_rclk;
    wire rf = rc_q & ~line_rclk;
    wire tx_edge = rloop ? rr : tf;
    wire rx_edge = lloop ? (rx_on_fall ? tf : tr) : (rx_on_fall ? rf : rr);

    AST_TX_ONE_RAIL: assert property (@(posedge clk) disable iff (rst)
        !(line_tpos && line_tneg)); // R2
    AST_RX_ONE_RAIL: assert property (@(posedge clk) disable iff (rst)
        !(sys_rpos && sys_rneg)); // R2
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tx_edge |=> $stable({line_tpos, line_tneg})); // R9
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rx_edge |=> $stable({sys_rpos, sys_rneg})); // R9
    AST_AIS_ZEROS: assert property (@(posedge clk) disable iff (rst)
        (!rloop && ais_en && !ais_ones && tf) |=> (!line_tpos && !line_tneg)); // R3
    AST_RLOOP_COPY: assert property (@(posedge clk) disable iff (rst)
        (rloop && rr) |=> (line_tpos == $past(line_rpos & ~line_rneg)
                        && line_tneg == $past(line_rneg & ~line_rpos))); // R7
endmodule

bind t1_chan_dp t1_chan_dp_chk u_chk (.*);

// File: tb/tb_t1_chan_dp.sv
module tb_t1_chan_dp;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sys_tclk = 1'b0, sys_tpos = 1'b0, sys_tneg = 1'b0;
    logic line_rclk = 1'b0, line_rpos = 1'b0, line_rneg = 1'b0;
    logic rx_on_fall = 1'b0, lloop = 1'b0, rloop = 1'b0, ais_en = 1'b0, ais_ones = 1'b0;
    logic line_tclk, line_tpos, line_tneg, sys_rclk, sys_rpos, sys_rneg;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    t1_chan_dp dut (.*);

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sys_tclk = 0; sys_tpos = 0; sys_tneg = 0;
        line_rclk = 0; line_rpos = 0; line_rneg = 0;
        rx_on_fall = 0; lloop = 0; rloop = 0; ais_en = 0; ais_ones = 0;
        step(3);
        rst = 1'b0;
        step(1);
    endtask

    task automatic drive_tx(input logic p, input logic n);
        sys_tpos = p; sys_tneg = n; sys_tclk = 1'b1;
        step(2);
        sys_tclk = 1'b0;
        step(2);
        sys_tclk = 1'b1;
        step(2);
    endtask

    task automatic drive_rx(input logic p, input logic n);
        line_rpos = p; line_rneg = n; line_rclk = 1'b0;
        step(2);
        line_rclk = 1'b1;
        step(2);
        line_rclk = 1'b0;
        step(2);
    endtask

    task automatic t_reset();
        do_reset();
        drive_rx(1, 0);
        drive_tx(0, 1);
        rst = 1'b1;
        step(2);
        chk("R8 rx rails in reset", {sys_rpos, sys_rneg}, 2'b00);
        chk("R8 tx rails in reset", {line_tpos, line_tneg}, 2'b00);
        rst = 1'b0;
        step(1);
    endtask

    task automatic t_tx_basic();
        do_reset();
        drive_tx(1, 0);
        chk("R1 tx positive mark", {line_tpos, line_tneg}, 2'b10);
        drive_tx(0, 1);
        chk("R1 tx negative mark", {line_tpos, line_tneg}, 2'b01);
        drive_tx(1, 1);
        chk("R2 tx both-high is zero", {line_tpos, line_tneg}, 2'b00);
        chk("R1 line_tclk follows sys_tclk high", {1'b0, line_tclk}, 2'b01);
        sys_tclk = 1'b0;
        step(1);
        chk("R1 line_tclk follows sys_tclk low", {1'b0, line_tclk}, 2'b00);
        sys_tclk = 1'b1;
        step(2);
    endtask

    task automatic t_hold();
        do_reset();
        drive_tx(1, 0);
        sys_tpos = 0; sys_tneg = 1;
        step(3);
        chk("R9 tx holds between edges", {line_tpos, line_tneg}, 2'b10);
    endtask

    task automatic t_ais_zero();
        do_reset();
        ais_en = 1; ais_ones = 0;
        drive_tx(1, 0);
        chk("R3 zero fill", {line_tpos, line_tneg}, 2'b00);
    endtask

    task automatic t_ais_ones();
        do_reset();
        ais_en = 1; ais_ones = 1;
        drive_tx(0, 0);
        chk("R4 first mark positive", {line_tpos, line_tneg}, 2'b10);
        drive_tx(0, 0);
        chk("R4 second mark negative", {line_tpos, line_tneg}, 2'b01);
        drive_tx(0, 1);
        chk("R4 third mark positive", {line_tpos, line_tneg}, 2'b10);
        drive_tx(1, 0);
        chk("R4 fourth mark negative", {line_tpos, line_tneg}, 2'b01);
    endtask

    task automatic t_rx_edge();
        do_reset();
        rx_on_fall = 0;
        line_rpos = 1; line_rneg = 0;
        step(2);
        line_rclk = 1;
        step(2);
        chk("R5 rise mode captures on rise", {sys_rpos, sys_rneg}, 2'b10);
        line_rpos = 0; line_rneg = 1;
        step(2);
        line_rclk = 0;
        step(2);
        chk("R5 rise mode ignores fall", {sys_rpos, sys_rneg}, 2'b10);
        rx_on_fall = 1;
        step(1);
        line_rclk = 1;
        step(2);
        chk("R5 fall mode ignores rise", {sys_rpos, sys_rneg}, 2'b10);
        line_rclk = 0;
        step(2);
        chk("R5 fall mode captures on fall", {sys_rpos, sys_rneg}, 2'b01);
        rx_on_fall = 0;
        drive_rx(1, 1);
        chk("R2 rx both-high is zero", {sys_rpos, sys_rneg}, 2'b00);
    endtask

    task automatic t_lloop();
        do_reset();
        lloop = 1;
        drive_tx(0, 1);
        chk("R6 rx carries tx bits", {sys_rpos, sys_rneg}, 2'b01);
        chk("R6 line still gets tx bits", {line_tpos, line_tneg}, 2'b01);
        drive_rx(1, 0);
        chk("R6 line rx data ignored", {sys_rpos, sys_rneg}, 2'b01);
        chk("R6 sys_rclk follows sys_tclk high", {1'b0, sys_rclk}, 2'b01);
        sys_tclk = 1'b0;
        step(1);
        chk("R6 sys_rclk follows sys_tclk low", {1'b0, sys_rclk}, 2'b00);
        sys_tclk = 1'b1;
        step(2);
    endtask

    task automatic t_rloop();
        do_reset();
        rloop = 1; ais_en = 1; ais_ones = 1;
        drive_rx(1, 0);
        chk("R7 retransmit positive", {line_tpos, line_tneg}, 2'b10);
        drive_rx(0, 1);
        chk("R7 retransmit negative", {line_tpos, line_tneg}, 2'b01);
        drive_tx(1, 0);
        chk("R7 system data and fill ignored", {line_tpos, line_tneg}, 2'b01);
        line_rclk = 1'b1;
        sys_tclk = 1'b0;
        step(1);
        chk("R7 line_tclk follows line_rclk", {1'b0, line_tclk}, 2'b01);
        drive_rx(1, 1);
        chk("R2 retransmit both-high is zero", {line_tpos, line_tneg}, 2'b00);
    endtask

    initial begin
        t_reset();
        t_tx_basic();
        t_hold();
        t_ais_zero();
        t_ais_ones();
        t_rx_edge();
        t_lloop();
        t_rloop();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule